// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is a single timer channel built around a 16-bit down counter. Software programs it through a small byte-wide write port: a control byte picks one of six operating modes, binary or decimal (BCD) counting, the source of the counting clock and the source of the gate. Two further writes supply the initial count, low byte first. The current count is always visible on a read port, and one output line carries the waveform of the selected mode: a level change at terminal count, a retriggerable one-shot, a rate pulse, a square wave or a one-clock strobe.

Counting advances once per rising edge of the selected clock source. That source is either an internal prescaled tick or an external clock pin, which passes through a synchronizer first. The gate comes from a constant high, an external pin (also synchronized) or a bit that software writes. Depending on the mode, a low gate suspends counting with the count kept, and a rising gate edge reloads the initial count and restarts the sequence.

All ports are plain control and status pins. None of them carries a stream of data, so there is no valid/ready handshake and no back-pressure. A write is taken in every cycle where `wr_en` is high.

Top module: `tmr_channel`

## Requirements
- R1: After reset `cnt_q` is 0 and `out_o` is high. The control state is mode 0, binary counting, internal tick and constant-high gate, and the software gate bit is 0.
- R2: `wr_sel` picks the target of a write: 0 is the control byte, 1 the count low byte, 2 the count high byte, and 3 the software gate (taken from `wr_data[0]`). A new count takes effect only on a high-byte write that follows a low-byte write. A low byte alone changes nothing that can be observed. A high-byte write with no low byte pending is ignored. When the count takes effect, `cnt_q` shows it in the next cycle.
- R3: The control byte holds the mode in bits [2:0], where values 6 and 7 act as modes 2 and 3. Bit 3 selects BCD counting, and bit 4 selects the external clock pin. Bits [6:5] select the gate: 0 and 3 mean constant high, 1 the external gate pin, 2 the software bit. A control write stops counting until a new count is written.
- R4: The count changes only on a count write, a gate reload, or a rising edge of the selected clock source. Each rising edge gives exactly one decrement, and a source held high does not count again. A rising edge on the external clock pin changes `cnt_q` at the third clock edge after the pin rises. The tick input has no effect while the external pin is selected.
- R5: In binary mode the counter decrements modulo 65536. In BCD mode each of the four digits wraps from 0 to 9, so 0x1000 goes to 0x0999 and 0 goes to 0x9999. An initial count of 0 therefore lasts 65536 counts in binary and 10000 counts in BCD.
- R6: In modes 0, 2, 3 and 4 a low gate suspends counting and keeps the count. In modes 1, 2, 3 and 5 a rising gate edge, once a count has been written, reloads the initial count and restarts. The reload acts one cycle after the software bit rises and three cycles after the gate pin rises.
- R7: Mode 0: a control write drives `out_o` low, and so does a count write. `out_o` goes high when the count reaches 0, and counting then stops.
- R8: Mode 1: a count write does not start counting. A gate edge loads the count and drives `out_o` low. `out_o` goes high at count 0. A new gate edge during the count restarts it, and the gate level has no effect.
- R9: Mode 2: counting starts on the count write. `out_o` is low while the count is 1. The clock edge after that reloads the initial count and drives `out_o` high, so the sequence repeats.
- R10: Mode 3: for an initial count N the output is high for ceil(N/2) counts and low for floor(N/2) counts, and the count reloads every N counts.
- R11: Modes 4 and 5 drive `out_o` low for exactly one clock cycle when the count reaches 0, after which counting stops. Mode 4 starts on the count write. Mode 5 starts on a gate edge, which does not change `out_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Write target: control, count low, count high, software gate |
| wr_data | input | 8 | Write data byte |
| tick_i | input | 1 | Internal prescaled counting tick |
| ext_clk_i | input | 1 | External counting clock pin (asynchronous) |
| ext_gate_i | input | 1 | External gate pin (asynchronous) |
| cnt_q | output | 16 | Current counter value |
| out_o | output | 1 | Channel output line |

## Verification
The hardest state to reach from the ports is a gate retrigger in mode 1 in the middle of a count. A related case is the single-cycle strobe of modes 4 and 5, because that edge depends on the gate's previous level and on the exact cycle of the terminal decrement. The bench reaches both through the software gate bit, which it writes low and then high at known cycles, with one-cycle tick pulses in between. Because of this, every reload and every terminal event lands on a cycle the bench can predict. The synchronized pin paths are covered separately: the bench holds the external clock and gate pins at known levels for counted cycles and checks that the count moves exactly three edges after each rising edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 16;
  localparam int DIGITS  = CNT_W / 4;
  localparam int LEN_W   = CNT_W + 1;
  localparam int BCD_MOD = 10 ** DIGITS;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_GATE = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    GS_HIGH  = 2'd0,
    GS_PIN   = 2'd1,
    GS_SOFT  = 2'd2,
    GS_HIGH2 = 2'd3
  } gsrc_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       bcd;
    logic       clk_ext;
    gsrc_e      gsrc;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [7:0] d);
    ctrl_t c;
    c.mode    = d[2:0];
    c.bcd     = d[3];
    c.clk_ext = d[4];
    c.gsrc    = gsrc_e'(d[6:5]);
    return c;
  endfunction

  // modes 6 and 7 behave as 2 and 3
  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
  endfunction

  // number of counts represented by an initial value
  function automatic logic [LEN_W-1:0] eff_len(input logic [CNT_W-1:0] v, input logic bcd);
    logic [LEN_W-1:0] acc;
    acc = '0;
    if (v == '0) begin
      acc = bcd ? LEN_W'(BCD_MOD) : (LEN_W'(1) << CNT_W);
    end else if (bcd) begin
      for (int i = DIGITS - 1; i >= 0; i--) begin
        acc = (acc * LEN_W'(10)) + LEN_W'(v[4*i +: 4]);
      end
    end else begin
      acc = {1'b0, v};
    end
    return acc;
  endfunction
endpackage

// File: rtl/tmr_dec.sv
module tmr_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] dec_o
);
  localparam int N = W / 4;

  logic [N-1:0] brw;
  logic [W-1:0] bcd_res;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < N; g++) begin : g_dig
    logic [3:0] d;
    assign d = val[4*g +: 4];
    assign bcd_res[4*g +: 4] = !brw[g] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    if (g < N - 1) begin : g_brw
      assign brw[g+1] = brw[g] && (d == 4'd0);
    end
  end

  assign dec_o = bcd ? bcd_res : (val - {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  ext_clk_i,
  input  logic  ext_gate_i,
  input  logic  sw_gate,
  input  logic  clk_ext,
  input  gsrc_e gsrc,
  output logic  cnt_en,
  output logic  gate_lvl,
  output logic  gate_rise
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clk_sync, gate_sync;
  logic src_sel, src_prev, gate_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sync  <= '0;
      gate_sync <= '0;
    end else begin
      clk_sync[0]  <= ext_clk_i;
      gate_sync[0] <= ext_gate_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        clk_sync[i]  <= clk_sync[i-1];
        gate_sync[i] <= gate_sync[i-1];
      end
    end
  end

  assign src_sel = clk_ext ? clk_sync[LAST] : tick_i;

  always_comb begin
    case (gsrc)
      GS_PIN:  gate_lvl = gate_sync[LAST];
      GS_SOFT: gate_lvl = sw_gate;
      default: gate_lvl = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_prev  <= 1'b0;
      gate_prev <= 1'b1;
    end else begin
      src_prev  <= src_sel;
      gate_prev <= gate_lvl;
    end
  end

  assign cnt_en    = src_sel && !src_prev;
  assign gate_rise = gate_lvl && !gate_prev;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  output ctrl_t            ctrl_q,
  output logic             ctrl_wr,
  output logic [2:0]       new_mode,
  output logic             commit,
  output logic [CNT_W-1:0] init_d,
  output logic             sw_gate
);
  logic [7:0] lo_q;
  logic       lo_ok;

  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign commit   = wr_en && (wr_sel == SEL_HI) && lo_ok;
  assign new_mode = wr_data[2:0];
  assign init_d   = {wr_data, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      lo_q    <= '0;
      lo_ok   <= 1'b0;
      sw_gate <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: begin
          ctrl_q <= decode_ctrl(wr_data);
          lo_ok  <= 1'b0;
        end
        SEL_LO: begin
          lo_q  <= wr_data;
          lo_ok <= 1'b1;
        end
        SEL_HI:  lo_ok   <= 1'b0;
        default: sw_gate <= wr_data[0];
      endcase
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [2:0]       new_mode,
  input  logic             commit,
  input  logic [CNT_W-1:0] init_d,
  input  logic [2:0]       mode_raw,
  input  logic             bcd,
  input  logic             cnt_en,
  input  logic             gate_lvl,
  input  logic             gate_rise,
  output logic [CNT_W-1:0] cnt_o,
  output logic             out_o,
  output logic             armed_o
);
  logic [CNT_W-1:0] init_q, cnt_r, dec_v;
  logic [LEN_W-1:0] ph_q, len, hi_len, ph_nxt;
  logic [2:0]       mode;
  logic             out_r, run_q, armed_q, strobe_q;
  logic             lvl_mode, trig_mode, one_shot, go;

  tmr_dec #(.W(CNT_W)) u_dec (.val(cnt_r), .bcd(bcd), .dec_o(dec_v));

  assign mode      = norm_mode(mode_raw);
  assign lvl_mode  = (mode == 3'd0) || (mode == 3'd2) || (mode == 3'd3) || (mode == 3'd4);
  assign trig_mode = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd3) || (mode == 3'd5);
  assign one_shot  = (mode == 3'd0) || (mode == 3'd1) || (mode == 3'd4) || (mode == 3'd5);
  assign len       = eff_len(init_q, bcd);
  assign hi_len    = (len + LEN_W'(1)) >> 1;
  assign ph_nxt    = ph_q + LEN_W'(1);
  assign go        = cnt_en && run_q && (gate_lvl || !lvl_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q   <= '0;
      cnt_r    <= '0;
      ph_q     <= '0;
      out_r    <= 1'b1;
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      if (strobe_q) begin
        out_r    <= 1'b1;
        strobe_q <= 1'b0;
      end
      if (ctrl_wr) begin
        run_q    <= 1'b0;
        armed_q  <= 1'b0;
        strobe_q <= 1'b0;
        out_r    <= (new_mode != 3'd0);
      end else if (commit) begin
        init_q   <= init_d;
        cnt_r    <= init_d;
        ph_q     <= '0;
        armed_q  <= 1'b1;
        run_q    <= lvl_mode;
        strobe_q <= 1'b0;
        out_r    <= (mode != 3'd0);
      end else if (gate_rise && armed_q && trig_mode) begin
        cnt_r    <= init_q;
        ph_q     <= '0;
        run_q    <= 1'b1;
        strobe_q <= 1'b0;
        out_r    <= (mode != 3'd1);
      end else if (go) begin
        if (one_shot) begin
          cnt_r <= dec_v;
          if (dec_v == '0) begin
            run_q <= 1'b0;
            if (mode == 3'd4 || mode == 3'd5) begin
              out_r    <= 1'b0;
              strobe_q <= 1'b1;
            end else begin
              out_r <= 1'b1;
            end
          end
        end else if (mode == 3'd2) begin
          if (cnt_r == CNT_W'(1)) begin
            cnt_r <= init_q;
            out_r <= 1'b1;
          end else begin
            cnt_r <= dec_v;
            out_r <= (dec_v != CNT_W'(1));
          end
        end else begin
          if (ph_q == len - LEN_W'(1)) begin
            cnt_r <= init_q;
            ph_q  <= '0;
            out_r <= 1'b1;
          end else begin
            cnt_r <= dec_v;
            ph_q  <= ph_nxt;
            out_r <= (ph_nxt < hi_len);
          end
        end
      end
    end
  end

  assign cnt_o   = cnt_r;
  assign out_o   = out_r;
  assign armed_o = armed_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             tick_i,
  input  logic             ext_clk_i,
  input  logic             ext_gate_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic             out_o
);
  ctrl_t            ctrl_q;
  logic             ctrl_wr, commit, sw_gate;
  logic [2:0]       new_mode, mode_raw;
  logic [CNT_W-1:0] init_d;
  logic             cnt_en, gate_lvl, gate_rise, armed;

  tmr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr), .new_mode(new_mode), .commit(commit),
    .init_d(init_d), .sw_gate(sw_gate)
  );

  tmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_clk_i(ext_clk_i),
    .ext_gate_i(ext_gate_i), .sw_gate(sw_gate), .clk_ext(ctrl_q.clk_ext),
    .gsrc(ctrl_q.gsrc), .cnt_en(cnt_en), .gate_lvl(gate_lvl), .gate_rise(gate_rise)
  );

  assign mode_raw = ctrl_q.mode;

  tmr_core u_core (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .new_mode(new_mode),
    .commit(commit), .init_d(init_d), .mode_raw(mode_raw), .bcd(ctrl_q.bcd),
    .cnt_en(cnt_en), .gate_lvl(gate_lvl), .gate_rise(gate_rise),
    .cnt_o(cnt_q), .out_o(out_o), .armed_o(armed)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [7:0]  wr_data,
  input logic [15:0] cnt_q,
  input logic        out_o,
  input logic        cnt_en,
  input logic        gate_rise,
  input logic        gate_lvl,
  input logic        armed,
  input logic [2:0]  mode_raw
);
  // R4: with no write, no clock edge and no gate reload the count holds
  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cnt_en && !gate_rise) |=> $stable(cnt_q));

  // R6: mode 0 with a low gate keeps its count
  a_r6_gate_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_raw == 3'd0 && !gate_lvl && !wr_en) |=> $stable(cnt_q));

  // R7: a control write selecting mode 0 pulls the output low
  a_r7_ctrl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[2:0] == 3'd0) |=> !out_o);

  // R8: a gate edge on an armed mode-1 channel pulls the output low
  a_r8_trigger_low: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_rise && armed && mode_raw == 3'd1 && !wr_en) |=> !out_o);

  // R11: the strobe of modes 4 and 5 lasts one cycle
  a_r11_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_o && (mode_raw == 3'd4 || mode_raw == 3'd5) && !wr_en) |=> out_o);
endmodule

bind tmr_channel tmr_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt_q(cnt_q), .out_o(out_o), .cnt_en(cnt_en), .gate_rise(gate_rise),
  .gate_lvl(gate_lvl), .armed(armed), .mode_raw(mode_raw)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        tick_i = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic        ext_gate_i = 1'b0;
  logic [15:0] cnt_q;
  logic        out_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [15:0] q_c[$];
  logic        q_o[$];
  string       q_t[$];

  tmr_channel u_tmr_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick_i(tick_i), .ext_clk_i(ext_clk_i), .ext_gate_i(ext_gate_i),
    .cnt_q(cnt_q), .out_o(out_o)
  );

  always #10 clk = ~clk;

  // driver side: push the expected state for the current sample point
  task automatic expect_st(input logic [15:0] c, input logic o, input string tag);
    q_c.push_back(c);
    q_o.push_back(o);
    q_t.push_back(tag);
  endtask

  // monitor side: pop and compare against the ports
  initial begin
    forever begin
      wait (q_c.size() != 0);
      #1;
      begin
        logic [15:0] c;
        logic o;
        string t;
        c = q_c.pop_front();
        o = q_o.pop_front();
        t = q_t.pop_front();
        n_chk++;
        if (cnt_q !== c || out_o !== o) begin
          n_err++;
          $display("FAIL %s: cnt=%h out=%b expected cnt=%h out=%b", t, cnt_q, out_o, c, o);
        end
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1;
    wr_sel = s;
    wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic tick();
    tick_i = 1'b0;
    cyc(1);
    tick_i = 1'b1;
    cyc(1);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: cnt=%h out=%b expected run to finish", cnt_q, out_o);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    expect_st(16'h0000, 1'b1, "R1 reset state");

    // mode 0, binary, internal tick
    wr(2'd0, 8'h00);
    expect_st(16'h0000, 1'b0, "R7 ctrl write drives low");
    wr(2'd1, 8'h03);
    expect_st(16'h0000, 1'b0, "R2 low byte alone");
    wr(2'd2, 8'h00);
    expect_st(16'h0003, 1'b0, "R2 count after high byte");
    tick(); expect_st(16'h0002, 1'b0, "R7 count 2");
    tick(); expect_st(16'h0001, 1'b0, "R7 count 1");
    tick(); expect_st(16'h0000, 1'b1, "R7 terminal high");
    tick(); expect_st(16'h0000, 1'b1, "R7 stops at zero");

    // byte order
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
    expect_st(16'h0000, 1'b0, "R2 high byte first ignored");
    load(16'h0005);
    expect_st(16'h0005, 1'b0, "R2 ordered load");

    // gate suspend through software bit
    wr(2'd0, 8'h40);
    load(16'h0004);
    tick(); expect_st(16'h0004, 1'b0, "R6 gate low suspends");
    wr(2'd3, 8'h01);
    tick(); expect_st(16'h0003, 1'b0, "R6 gate high resumes");

    // BCD and zero count
    wr(2'd0, 8'h08);
    load(16'h1000);
    tick(); expect_st(16'h0999, 1'b0, "R5 bcd digit borrow");
    tick(); expect_st(16'h0998, 1'b0, "R5 bcd step");
    wr(2'd0, 8'h08);
    load(16'h0000);
    tick(); expect_st(16'h9999, 1'b0, "R5 bcd zero wraps");
    wr(2'd0, 8'h00);
    load(16'h0000);
    tick(); expect_st(16'hFFFF, 1'b0, "R5 binary zero wraps");

    // mode 2
    wr(2'd0, 8'h02);
    load(16'h0003);
    expect_st(16'h0003, 1'b1, "R9 start");
    tick(); expect_st(16'h0002, 1'b1, "R9 count 2");
    tick(); expect_st(16'h0001, 1'b0, "R9 low at one");
    tick(); expect_st(16'h0003, 1'b1, "R9 reload");
    tick(); expect_st(16'h0002, 1'b1, "R9 second period");

    // modes 6 and 7 alias to 2 and 3
    wr(2'd0, 8'h06);
    load(16'h0002);
    tick(); expect_st(16'h0001, 1'b0, "R3 mode 6 as 2 low");
    tick(); expect_st(16'h0002, 1'b1, "R3 mode 6 as 2 reload");

    // mode 3, N = 5
    wr(2'd0, 8'h03);
    load(16'h0005);
    expect_st(16'h0005, 1'b1, "R10 start high");
    tick(); expect_st(16'h0004, 1'b1, "R10 high 2");
    tick(); expect_st(16'h0003, 1'b1, "R10 high 3");
    tick(); expect_st(16'h0002, 1'b0, "R10 low 1");
    tick(); expect_st(16'h0001, 1'b0, "R10 low 2");
    tick(); expect_st(16'h0005, 1'b1, "R10 reload high");
    wr(2'd0, 8'h07);
    load(16'h0004);
    tick(); expect_st(16'h0003, 1'b1, "R10 even high");
    tick(); expect_st(16'h0002, 1'b0, "R10 even low");

    // mode 1 retriggerable one-shot
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h41);
    load(16'h0003);
    expect_st(16'h0003, 1'b1, "R8 waits for gate");
    tick(); expect_st(16'h0003, 1'b1, "R8 no count before trigger");
    wr(2'd3, 8'h01);
    cyc(1); expect_st(16'h0003, 1'b0, "R8 trigger low");
    tick(); expect_st(16'h0002, 1'b0, "R8 count 2");
    tick(); expect_st(16'h0001, 1'b0, "R8 count 1");
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h01);
    cyc(1); expect_st(16'h0003, 1'b0, "R8 retrigger reload");
    wr(2'd3, 8'h00);
    tick(); expect_st(16'h0002, 1'b0, "R8 gate level ignored");
    tick(); tick(); expect_st(16'h0000, 1'b1, "R8 terminal high");

    // mode 4 strobe
    wr(2'd0, 8'h04);
    load(16'h0002);
    expect_st(16'h0002, 1'b1, "R11 mode4 start");
    tick(); expect_st(16'h0001, 1'b1, "R11 mode4 count");
    tick(); expect_st(16'h0000, 1'b0, "R11 mode4 strobe low");
    cyc(1); expect_st(16'h0000, 1'b1, "R11 mode4 strobe ends");
    tick(); expect_st(16'h0000, 1'b1, "R11 mode4 stopped");

    // mode 5 gate-triggered strobe
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h45);
    load(16'h0002);
    tick(); expect_st(16'h0002, 1'b1, "R11 mode5 waits");
    wr(2'd3, 8'h01);
    cyc(1); expect_st(16'h0002, 1'b1, "R11 mode5 trigger keeps high");
    tick(); expect_st(16'h0001, 1'b1, "R11 mode5 count");
    tick(); expect_st(16'h0000, 1'b0, "R11 mode5 strobe low");
    cyc(1); expect_st(16'h0000, 1'b1, "R11 mode5 strobe ends");

    // external clock pin
    wr(2'd0, 8'h10);
    load(16'h0002);
    tick(); expect_st(16'h0002, 1'b0, "R4 tick ignored on external clock");
    ext_clk_i = 1'b1;
    cyc(2); expect_st(16'h0002, 1'b0, "R4 sync latency");
    cyc(1); expect_st(16'h0001, 1'b0, "R4 third edge counts");
    cyc(3); expect_st(16'h0001, 1'b0, "R4 held high once");
    ext_clk_i = 1'b0;
    cyc(3);
    ext_clk_i = 1'b1;
    cyc(3); expect_st(16'h0000, 1'b1, "R4 second edge");

    // external gate pin, mode 2
    wr(2'd0, 8'h22);
    load(16'h0005);
    tick(); expect_st(16'h0005, 1'b1, "R6 pin gate low suspends");
    ext_gate_i = 1'b1;
    cyc(4);
    tick(); expect_st(16'h0004, 1'b1, "R6 pin gate high counts");
    tick(); expect_st(16'h0003, 1'b1, "R6 count 3");
    ext_gate_i = 1'b0;
    cyc(4);
    ext_gate_i = 1'b1;
    cyc(2); expect_st(16'h0003, 1'b1, "R6 pin edge not yet");
    cyc(1); expect_st(16'h0005, 1'b1, "R6 pin edge reload");

    wait (q_c.size() == 0);
    #5;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule